// File: doc/BRIEF.md
# Reference Divider with Fast-Lock Boost Window

This block turns a reference clock into the comparison pulse that a phase detector compares against the divided oscillator. The division has two stages. A fixed divide-by-4 stage comes first. Its tick then drives a programmable down-counter loaded from a 16-bit divisor B. The overall ratio is therefore 4 × B, which covers 20 to 262140. A divisor below 5 is treated as 5. A new divisor is picked up only when the counter reloads, so the period in progress always runs to its end.

The block also times a fast-lock boost window, measured in comparison periods. The window starts when the operate input rises, or when the control register reports a completed write while the block is operating. While the window is open and the 5-bit level code is not zero, the block enables the boost driver and presents the code on the level bus. Once two comparison pulses have passed, the driver returns to high impedance. When operate is low, the block is in standby: both counters are held reset, the driver is off and no pulses are issued.

Top module: `refdiv_fastlock`

## Requirements
- R1: `fr_o` is high for exactly one clock. While operating with a steady divisor, consecutive pulses are exactly 4 × B_eff clocks apart, where B_eff is `div_b_i`, or 5 if `div_b_i` is below 5.
- R2: Count the first rising clock edge that samples `operate_i` high as edge 1. The first `fr_o` pulse after operate rises is then high just after edge 4 × B_eff.
- R3: A `div_b_i` value from 0 to 4 divides exactly like a value of 5, giving 20 clocks per pulse.
- R4: A divisor change during a period does not shorten that period. The new value sets the length of the periods that follow the next pulse.
- R5: While `operate_i` is low, `fr_o` is 0 and `boost_oe_o` is 0 from the next clock onward. Both counters restart from zero when operate returns.
- R6: When `operate_i` rises and `boost_code_i` is not zero, `boost_oe_o` is 1 from the next clock onward.
- R7: A one-clock `load_i` pulse while `operate_i` is high restarts the boost window. `boost_oe_o` is 1 from the next clock onward, even if a window has already ended.
- R8: The window closes on the clock after the second `fr_o` pulse that follows its trigger. `boost_oe_o` stays 1 up to and including the cycle in which that second pulse is high.
- R9: When `boost_code_i` is 0, `boost_oe_o` stays 0 and `boost_lvl_o` stays 0.
- R10: `boost_lvl_o` equals `boost_code_i` while `boost_oe_o` is 1, and is 0 otherwise.
- R11: A `load_i` pulse while `operate_i` is low has no effect: `boost_oe_o` and `fr_o` stay 0.
- R12: With B = 144, pulses are 576 clocks apart, which gives 25 kHz from a 14.4 MHz reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| operate_i | input | 1 | 1 = run, 0 = standby |
| load_i | input | 1 | One-clock pulse marking a completed register write |
| div_b_i | input | 16 | Programmable divisor B |
| boost_code_i | input | 5 | Boost level code; 0 disables the boost |
| fr_o | output | 1 | Comparison pulse, one clock wide |
| boost_lvl_o | output | 5 | Boost level presented to the driver |
| boost_oe_o | output | 1 | Boost driver enable; 0 = high impedance |

## Verification
The bench sweeps every divisor from 0 to 12, plus 144. For each one it predicts, cycle by cycle, where the first pulse and each later pulse should fall, and where the boost window should close. Each of the following design errors moves a predicted pulse or window edge and is caught there:
- the reload off by one, which shifts every pulse by four clocks;
- a missing clamp, which makes small divisors divide short;
- an immediate reload on a divisor change, which cuts the running period short;
- a window that counts one pulse too few or too many.

Further runs raise `load_i` mid-operation, with a zero code, and in standby. These catch a retrigger that is ignored, a zero code that still enables the driver, and a standby load that starts a window.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  parameter int unsigned PRE_DIV_DEF   = 4;
  parameter int unsigned B_MIN_DEF     = 5;
  parameter int unsigned BOOST_FR_DEF  = 2;
  parameter int unsigned B_W_DEF       = 16;
  parameter int unsigned CODE_W_DEF    = 5;
endpackage

// File: rtl/refdiv_prescaler.sv
module refdiv_prescaler #(
  parameter int unsigned PRE_DIV = refdiv_pkg::PRE_DIV_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (PRE_DIV > 1) begin : g_div
      localparam int unsigned PW = $clog2(PRE_DIV);
      localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
      logic [PW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (!run_i)        cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = run_i && (cnt_q == LAST);

      // R1: ticks never come back to back
      a_r1_tick_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end else begin : g_pass
      assign tick_o = run_i;
    end
  endgenerate
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int unsigned B_W   = refdiv_pkg::B_W_DEF,
  parameter int unsigned B_MIN = refdiv_pkg::B_MIN_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           tick_i,
  input  logic [B_W-1:0] div_b_i,
  output logic           fr_o
);
  localparam logic [B_W-1:0] MIN_V = B_W'(B_MIN);

  logic [B_W-1:0] b_eff, reload, cnt_q;
  logic           fr_q;

  assign b_eff  = (div_b_i < MIN_V) ? MIN_V : div_b_i;
  assign reload = b_eff - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= MIN_V - 1'b1;
      fr_q  <= 1'b0;
    end else if (!run_i) begin
      // standby: preload so the first period after start is full length
      cnt_q <= reload;
      fr_q  <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == '0) begin
        cnt_q <= reload;
        fr_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        fr_q  <= 1'b0;
      end
    end else begin
      fr_q <= 1'b0;
    end
  end

  assign fr_o = fr_q;

  a_r1_fr_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_o |=> !fr_o);
  // R3: reload never below the clamp
  a_r3_reload_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_o |-> cnt_q >= MIN_V - 1'b1);
  a_r5_standby_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !fr_o);
endmodule

// File: rtl/refdiv_boost.sv
module refdiv_boost #(
  parameter int unsigned CODE_W   = refdiv_pkg::CODE_W_DEF,
  parameter int unsigned BOOST_FR = refdiv_pkg::BOOST_FR_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              operate_i,
  input  logic              load_i,
  input  logic              fr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              oe_o,
  output logic [CODE_W-1:0] lvl_o
);
  localparam int unsigned CW = $clog2(BOOST_FR + 1);
  localparam logic [CW-1:0] START = CW'(BOOST_FR);

  logic          op_q, trig;
  logic [CW-1:0] win_q;

  assign trig = operate_i && (!op_q || load_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= 1'b0;
      win_q <= '0;
    end else begin
      op_q <= operate_i;
      if (!operate_i)                win_q <= '0;
      else if (trig)                 win_q <= START;  // retrigger wins over a pulse
      else if (fr_i && win_q != '0)  win_q <= win_q - 1'b1;
    end
  end

  assign oe_o  = (win_q != '0) && (code_i != '0);
  assign lvl_o = oe_o ? code_i : '0;

  a_r5_standby_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !operate_i |=> !oe_o);
  a_r6_start_on_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (operate_i && !op_q && code_i != '0) |=> (oe_o || code_i == '0));
  a_r7_start_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (operate_i && load_i && code_i != '0) |=> (oe_o || code_i == '0));
  a_r8_window_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (operate_i && !trig && fr_i && win_q == CW'(1)) |=> !oe_o);
  a_r9_zero_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == '0) |-> (!oe_o && lvl_o == '0));
endmodule

// File: rtl/refdiv_fastlock.sv
module refdiv_fastlock #(
  parameter int unsigned B_W      = refdiv_pkg::B_W_DEF,
  parameter int unsigned CODE_W   = refdiv_pkg::CODE_W_DEF,
  parameter int unsigned PRE_DIV  = refdiv_pkg::PRE_DIV_DEF,
  parameter int unsigned B_MIN    = refdiv_pkg::B_MIN_DEF,
  parameter int unsigned BOOST_FR = refdiv_pkg::BOOST_FR_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              operate_i,
  input  logic              load_i,
  input  logic [B_W-1:0]    div_b_i,
  input  logic [CODE_W-1:0] boost_code_i,
  output logic              fr_o,
  output logic [CODE_W-1:0] boost_lvl_o,
  output logic              boost_oe_o
);
  logic tick;

  refdiv_prescaler #(.PRE_DIV(PRE_DIV)) i_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(operate_i), .tick_o(tick)
  );

  refdiv_counter #(.B_W(B_W), .B_MIN(B_MIN)) i_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(operate_i), .tick_i(tick),
    .div_b_i(div_b_i), .fr_o(fr_o)
  );

  refdiv_boost #(.CODE_W(CODE_W), .BOOST_FR(BOOST_FR)) i_bst (
    .clk_i(clk_i), .rst_ni(rst_ni), .operate_i(operate_i), .load_i(load_i),
    .fr_i(fr_o), .code_i(boost_code_i), .oe_o(boost_oe_o), .lvl_o(boost_lvl_o)
  );

  // R2: a pulse only follows a prescaler tick
  a_r2_fr_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_o |-> $past(tick));
  a_r10_level_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boost_oe_o ? boost_lvl_o == boost_code_i : boost_lvl_o == '0));
endmodule

// File: tb/test_refdiv_fastlock.sv
module test_refdiv_fastlock;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        operate = 1'b0;
  logic        load = 1'b0;
  logic [15:0] div_b = 16'd5;
  logic [4:0]  code = 5'd0;
  logic        fr;
  logic [4:0]  lvl;
  logic        oe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  refdiv_fastlock i_refdiv_fastlock (
    .clk_i(clk), .rst_ni(rst_ni), .operate_i(operate), .load_i(load),
    .div_b_i(div_b), .boost_code_i(code), .fr_o(fr), .boost_lvl_o(lvl),
    .boost_oe_o(oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_boost(input int frs, input string tag);
    bit e_oe = (code != 0) && (frs < 2);
    chk(oe == e_oe, {tag, " oe"}, int'(oe), int'(e_oe));
    chk(lvl == (e_oe ? code : 5'd0), "R10 lvl", int'(lvl), e_oe ? int'(code) : 0);
  endtask

  // operate rises; check pulse grid and boost window for ncyc cycles
  task automatic run_start(input int b, input int cd, input int ncyc, input string tag);
    int be = (b < 5) ? 5 : b;
    int frs = 0;
    div_b = 16'(b); code = 5'(cd);
    @(negedge clk); operate = 1'b1;
    for (int n = 1; n <= ncyc; n++) begin
      @(negedge clk);
      chk(fr == ((n % (4*be)) == 0), tag, int'(fr), int'((n % (4*be)) == 0));
      chk_boost(frs, "R6/R8");
      if (fr) frs++;
    end
  endtask

  task automatic stop_run();
    @(negedge clk); operate = 1'b0;
    @(negedge clk);
    chk(!fr && !oe, "R5 standby", int'({fr, oe}), 0);
    @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!fr && !oe && lvl == 0, "R5 reset state", int'({fr, oe, lvl}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!fr && !oe, "R5 idle", int'({fr, oe}), 0);

    // sweep divisors including clamped ones (R3) and zero code (R9)
    for (int b = 0; b <= 12; b++) begin
      int be = (b < 5) ? 5 : b;
      run_start(b, (b % 4 == 0) ? 0 : b + 3, 12*be + 3, (b < 5) ? "R3 clamp" : "R1/R2 grid");
      stop_run();
    end

    // R12: example divisor
    run_start(144, 17, 1200, "R12 b144");
    stop_run();

    // R4: divisor change mid-period
    begin
      int frs = 0;
      div_b = 16'd6; code = 5'd9;
      @(negedge clk); operate = 1'b1;
      for (int n = 1; n <= 140; n++) begin
        bit e;
        @(negedge clk);
        if (n == 10) div_b = 16'd9;
        e = (n == 24) || (n > 24 && ((n - 24) % 36) == 0);
        chk(fr == e, "R4 reload", int'(fr), int'(e));
        chk_boost(frs, "R8");
        if (fr) frs++;
      end
      // now at n=140 (fr at 132, next 168); R7 retrigger
      begin
        int fr2 = 0;
        load = 1'b1;
        @(negedge clk); load = 1'b0;
        for (int k = 0; k < 90; k++) begin
          chk_boost(fr2, "R7 load");
          if (fr) fr2++;
          @(negedge clk);
        end
      end
      // R9: load with zero code
      code = 5'd0;
      load = 1'b1;
      @(negedge clk); load = 1'b0;
      for (int k = 0; k < 10; k++) begin
        chk(!oe && lvl == 0, "R9 zero code", int'({oe, lvl}), 0);
        @(negedge clk);
      end
      // R5: drop operate mid window
      code = 5'd3;
      load = 1'b1;
      @(negedge clk); load = 1'b0;
      chk(oe == 1'b1, "R7 load2", int'(oe), 1);
      operate = 1'b0;
      @(negedge clk);
      chk(!oe && !fr, "R5 drop", int'({oe, fr}), 0);
    end

    // R11: load in standby ignored
    repeat (3) @(negedge clk);
    load = 1'b1;
    @(negedge clk); load = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk(!oe && !fr && lvl == 0, "R11 standby load", int'({oe, fr}), 0);
      @(negedge clk);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule